// File: doc/BRIEF.md
# Hold-to-Request/Grant Bus Handover Bridge

This block lets a requester that speaks a plain level handshake (assert a hold request, wait for an acknowledge level) borrow the bus from a processor that hands over its bus through pulses on one shared, active-low, open-drain line. The bridge turns the level protocol into a three-pulse exchange: a request pulse from the bridge, a grant pulse from the processor, and a release pulse from the bridge. Each pulse is one clock wide.

The hold request is active low and may arrive from another clock domain, so it passes through a flip-flop synchronizer first. Once the request is seen, the bridge pulls the shared line low for exactly one clock. It then lets go of the line and waits for the processor to pull it low. That grant raises the acknowledge output. When the request goes away, the bridge pulls the line low for one more clock to give the bus back. The acknowledge drops one clock after that pulse ends. The bridge pulls the line only during its own pulses, so it can read the processor's pulse on the same wire without contention.

Top module: `hold_rg_bridge`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, `rg_pull_o` and `hold_ack` are 0.
- R2: When `hold_req_n` goes low (asserted) from idle, `rg_pull_o` goes to 1 (1 means the line is driven low) for exactly one clock. With the default two synchronizer stages, it rises on the third rising edge after the input changes.
- R3: After a request pulse, the first clock edge that samples `rg_line_i` at 0 (line low, which is the grant) sets `hold_ack` to 1 on that same edge.
- R4: When `hold_req_n` returns high while acknowledged, `rg_pull_o` goes to 1 for exactly one clock, on the third rising edge after the change.
- R5: `hold_ack` goes to 0 one clock after the release pulse ends, which is two edges after the release pulse began.
- R6: The bridge never drives the line in two consecutive cycles, and it does not drive the line while the bus is held. `rg_line_i` then reads 1 unless the processor pulls it.
- R7: A low level on `rg_line_i` is ignored when no request is outstanding, and also while the bus is already held. Neither `hold_ack` nor `rg_pull_o` changes.
- R8: If the hold request is withdrawn before the grant arrives, the bridge still waits for the grant. On the grant edge, `hold_ack` rises and the release pulse starts together. `hold_ack` falls two edges later.
- R9: A reset in the middle of a held handover drops `hold_ack` on the reset edge. A later request then completes a normal handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req_n | input | 1 | Active-low hold request (asynchronous) |
| rg_line_i | input | 1 | Sampled level of the shared request/grant line (0 = low) |
| rg_pull_o | output | 1 | 1 = the bridge pulls the shared line low this cycle |
| hold_ack | output | 1 | Hold acknowledge level |

## Verification
The handshake is tried with four patterns:
- A plain request and release, which pins down the exact edge of each pulse and of each acknowledge change.
- Stray low pulses on the line, once while idle and once while held, which separate a bridge that honours only an expected grant from one that reacts to any low level.
- A request withdrawn before its grant, which shows whether the bridge waits for the grant and then releases at once, or drops the handshake halfway.
- A reset during a held transfer followed by a fresh request, which shows that nothing stale survives the reset.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_HELD,
    ST_REL,
    ST_TAIL
  } brg_state_e;
endpackage

// File: rtl/brg_sync.sv
module brg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RST_VAL;
        else     chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/brg_fsm.sv
module brg_fsm
  import brg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_act,
  input  logic line_i,
  output logic pull_o,
  output logic ack_o
);
  brg_state_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      pull_o <= 1'b0;
      ack_o  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_act) begin
            pull_o <= 1'b1;
            st_q   <= ST_REQ;
          end
        end
        ST_REQ: begin
          pull_o <= 1'b0;
          st_q   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!line_i) begin
            ack_o <= 1'b1;
            if (!req_act) begin
              pull_o <= 1'b1;
              st_q   <= ST_REL;
            end else begin
              st_q <= ST_HELD;
            end
          end
        end
        ST_HELD: begin
          if (!req_act) begin
            pull_o <= 1'b1;
            st_q   <= ST_REL;
          end
        end
        ST_REL: begin
          pull_o <= 1'b0;
          st_q   <= ST_TAIL;
        end
        ST_TAIL: begin
          ack_o <= 1'b0;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    pull_o |=> !pull_o);  // R6

  AST_ACK_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(!line_i));  // R3

  AST_ACK_FALL_AFTER_REL: assert property (@(posedge clk) disable iff (rst)
    ($fell(ack_o) && !$past(rst)) |-> $past(pull_o, 2));  // R5

  AST_STRAY_GNT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !line_i && !req_act) |=> !ack_o);  // R7
endmodule

// File: rtl/hold_rg_bridge.sv
module hold_rg_bridge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req_n,
  input  logic rg_line_i,
  output logic rg_pull_o,
  output logic hold_ack
);
  logic req_n_sync;

  brg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (hold_req_n),
    .q   (req_n_sync)
  );

  brg_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req_act (~req_n_sync),
    .line_i  (rg_line_i),
    .pull_o  (rg_pull_o),
    .ack_o   (hold_ack)
  );
endmodule

// File: tb/hold_rg_bridge_tb_top.sv
module hold_rg_bridge_tb_top;
  localparam int GDLY = 3;
  localparam int K_PR = 0, K_PF = 1, K_AR = 2, K_AF = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_n = 1'b1;
  logic proc_pull = 1'b0;
  logic stray_pull = 1'b0;
  logic line;
  logic rg_pull_o, hold_ack;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  int    q_kind[$];
  int    q_cyc[$];
  string q_tag[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign line = ~(rg_pull_o | proc_pull | stray_pull);

  hold_rg_bridge dut_i (
    .clk        (clk),
    .rst        (rst),
    .hold_req_n (hold_n),
    .rg_line_i  (line),
    .rg_pull_o  (rg_pull_o),
    .hold_ack   (hold_ack)
  );

  // processor model: grants a request pulse GDLY clocks later, takes a release back
  bit lent = 0;
  int gcnt = 0;
  logic pprev = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      lent = 0; gcnt = 0; proc_pull = 1'b0;
    end else begin
      proc_pull = 1'b0;
      if (gcnt != 0) begin
        gcnt = gcnt - 1;
        if (gcnt == 0) proc_pull = 1'b1;
      end
      if (rg_pull_o && !pprev) begin
        if (!lent) begin lent = 1; gcnt = GDLY; end
        else lent = 0;
      end
    end
    pprev = rg_pull_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_exp(input int kind, input int at, input string tag);
    q_kind.push_back(kind);
    q_cyc.push_back(at);
    q_tag.push_back(tag);
  endtask

  task automatic take_event(input int kind);
    int ek, ec;
    string et;
    if (q_kind.size() == 0) begin
      chk(0, "unexpected output event (R6/R7)", kind, -1);
    end else begin
      ek = q_kind.pop_front();
      ec = q_cyc.pop_front();
      et = q_tag.pop_front();
      chk(ek == kind, {et, " event kind"}, kind, ek);
      chk(ec == cyc, {et, " event cycle"}, cyc, ec);
    end
  endtask

  // monitor: turn output changes into events and compare with the expected queue
  logic mp = 1'b0, ma = 1'b0;
  always @(negedge clk) begin
    if (rg_pull_o && !mp) take_event(K_PR);
    if (!rg_pull_o && mp) take_event(K_PF);
    if (hold_ack && !ma) take_event(K_AR);
    if (!hold_ack && ma) take_event(K_AF);
    mp = rg_pull_o;
    ma = hold_ack;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_request(input string tag);
    int n;
    @(negedge clk);
    n = cyc;
    hold_n = 1'b0;
    push_exp(K_PR, n + 3, {tag, " R2 request rise"});
    push_exp(K_PF, n + 4, {tag, " R2 request fall"});
    push_exp(K_AR, n + 4 + GDLY, {tag, " R3 ack rise"});
  endtask

  task automatic do_release(input string tag);
    int r;
    @(negedge clk);
    r = cyc;
    hold_n = 1'b1;
    push_exp(K_PR, r + 3, {tag, " R4 release rise"});
    push_exp(K_PF, r + 4, {tag, " R4 release fall"});
    push_exp(K_AF, r + 5, {tag, " R5 ack fall"});
  endtask

  task automatic stray_pulse;
    @(negedge clk);
    stray_pull = 1'b1;
    @(negedge clk);
    stray_pull = 1'b0;
  endtask

  initial begin
    int n, k;
    wait_n(3);
    chk(rg_pull_o == 1'b0, "R1 pull in reset", rg_pull_o, 0);
    chk(hold_ack == 1'b0, "R1 ack in reset", hold_ack, 0);
    rst = 1'b0;
    wait_n(1);
    chk(rg_pull_o == 1'b0 && hold_ack == 1'b0, "R1 after reset", {rg_pull_o, hold_ack}, 0);
    wait_n(3);

    // plain handshake
    do_request("basic");
    wait_n(10);
    chk(hold_ack == 1'b1, "R3 ack held", hold_ack, 1);
    chk(line == 1'b1, "R6 line released while held", line, 1);
    do_release("basic");
    wait_n(8);
    chk(hold_ack == 1'b0, "R5 ack low after release", hold_ack, 0);

    // stray grant while idle
    stray_pulse();
    wait_n(5);
    chk(hold_ack == 1'b0, "R7 stray grant idle ack", hold_ack, 0);
    chk(rg_pull_o == 1'b0, "R7 stray grant idle pull", rg_pull_o, 0);

    // stray low while held
    do_request("held");
    wait_n(10);
    stray_pulse();
    wait_n(4);
    chk(hold_ack == 1'b1, "R7 stray low while held", hold_ack, 1);
    do_release("held");
    wait_n(8);

    // request withdrawn before grant
    @(negedge clk);
    n = cyc;
    hold_n = 1'b0;
    push_exp(K_PR, n + 3, "early R2 request rise");
    push_exp(K_PF, n + 4, "early R2 request fall");
    push_exp(K_PR, n + 4 + GDLY, "early R8 release rise");
    push_exp(K_AR, n + 4 + GDLY, "early R8 ack rise");
    push_exp(K_PF, n + 5 + GDLY, "early R8 release fall");
    push_exp(K_AF, n + 6 + GDLY, "early R8 ack fall");
    wait_n(2);
    hold_n = 1'b1;
    wait_n(12);
    chk(hold_ack == 1'b0, "R8 ack low at end", hold_ack, 0);

    // reset during held transfer
    do_request("prereset");
    wait_n(10);
    @(negedge clk);
    k = cyc;
    rst = 1'b1;
    hold_n = 1'b1;
    push_exp(K_AF, k + 1, "R9 ack drop on reset");
    @(negedge clk);
    rst = 1'b0;
    wait_n(6);
    chk(hold_ack == 1'b0 && rg_pull_o == 1'b0, "R9 idle after reset", {rg_pull_o, hold_ack}, 0);
    do_request("postreset R9");
    wait_n(10);
    do_release("postreset R9");
    wait_n(8);

    chk(q_kind.size() == 0, "R2-R9 missing expected events", q_kind.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule